// File: doc/BRIEF.md
# Interrupt Save-State Capture Controller

This block records where an in-order core must resume, and with what machine-state word, whenever an interrupt is taken. Three request lines carry the interrupt class: machine check, critical and noncritical. A guest flag sends a noncritical request to a separate guest pair. The block owns the live state word. On an interrupt it writes the resume address and the pre-interrupt state word into one of four save/restore pairs, then clears class-specific enable bits in the live word. A return instruction names one of the pairs; the block drives that pair's address out as the redirect target and reloads the live word from it.

Two exceptions may be held back and delivered later. The first is a debug exception, recorded in a sticky status register while debug interrupts are off. The second is a floating-point enabled exception, pending outside the block while its exception mode is precise-disabled. When a state write or a return turns the relevant enable on, a trigger arms with a saved address. For a plain state write that address is the next sequential address. For a return it is the return's target. On the following cycle the trigger is taken as an ordinary interrupt into the critical pair or the noncritical pair.

Top module: `irq_state_capture`

## Requirements
- R1: A critical request that wins arbitration writes `resume_pc` and the pre-interrupt state word into the critical pair (index 1) on the next edge. The noncritical pair is left unchanged.
- R2: A winning noncritical request writes into the noncritical pair (index 0). If `req_guest` is also high, it writes into the guest pair (index 2) instead.
- R3: A machine-check request writes into its own pair (index 3) and into no other.
- R4: Simultaneous requests resolve in the order machine check, critical, noncritical, and only the winner's pair is written. In a cycle that takes an interrupt, a return or a state write is ignored.
- R5: On an interrupt the live state word becomes the old word with class bits cleared:
  - machine check clears bits 15, 12 and 9;
  - critical and delayed debug clear bits 15 and 9;
  - noncritical and delayed floating-point clear bit 15.
- R6: Debug status bits are set by `dbg_evt` and stay set until `dbg_clr` writes a one to the same bit.
- R7: When a state write raises the debug-enable bit (bit 9) from 0 to 1 while any debug status bit is set, a critical interrupt is taken on the next cycle. It saves `seq_pc` into the critical pair.
- R8: When a return raises the debug-enable bit under the same condition, the delayed interrupt saves the return target rather than `seq_pc`.
- R9: When a state write or return changes the mode bits (bits 11 and 8) to a nonzero value while `fp_exc_pend` is high, a noncritical interrupt is taken on the next cycle into pair 0. It saves the next sequential address or the return target. No interrupt follows when `fp_exc_pend` is low.
- R10: `fp_precise_o` is high exactly when state bits 11 and 8 are both 0.
- R11: A return with `ret_kind` 0 (normal), 1 (critical), 2 (guest) or 3 (machine check) shows that pair's address on `ret_pc_o` in the same cycle. It reloads the live word from that pair on the next edge.
- R12: After reset the live word, every pair and the debug status are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_mc | input | 1 | Machine-check request |
| req_crit | input | 1 | Critical request |
| req_nc | input | 1 | Noncritical request |
| req_guest | input | 1 | Noncritical request is directed to guest state |
| resume_pc | input | AW | Address to resume at for an external request |
| seq_pc | input | AW | Next sequential address after the current instruction |
| wr_state_v | input | 1 | Software writes the state word this cycle |
| wr_state | input | MW | Value written to the state word |
| ret_v | input | 1 | Return-from-interrupt instruction completes |
| ret_kind | input | 2 | Pair used by the return |
| dbg_evt | input | DW | Debug exception events |
| dbg_clr | input | DW | Write-one-to-clear of debug status |
| fp_exc_pend | input | 1 | Floating-point enabled exception pending |
| state_o | output | MW | Live machine-state word |
| fp_precise_o | output | 1 | Floating-point exceptions in precise mode |
| ret_done_o | output | 1 | Return accepted this cycle |
| ret_pc_o | output | AW | Address restored by the selected pair |
| dbg_status_o | output | DW | Sticky debug status |
| pair_pc_o | output | 4 x AW | Saved addresses, pairs 0 to 3 |
| pair_state_o | output | 4 x MW | Saved state words, pairs 0 to 3 |

## Verification
The properties assume the request, return and write strobes are sampled only at rising edges. They also assume `ret_kind` is always one of the four defined codes. The stimulus drives every input on the falling edge and always holds `ret_kind` at a legal code, even when `ret_v` is low. The delayed-trigger property also assumes a trigger is never armed twice before it is taken. The bench keeps to this by letting each armed interrupt be taken on an idle cycle before the next enabling write.

// File: rtl/isc_pkg.sv
package isc_pkg;
   localparam int PAIRS = 4;

   typedef enum logic [1:0] {
      PR_NORM  = 2'd0,
      PR_CRIT  = 2'd1,
      PR_GUEST = 2'd2,
      PR_MCHK  = 2'd3
   } pair_e;

   typedef enum logic [2:0] {
      SRC_NONE = 3'd0,
      SRC_MCHK = 3'd1,
      SRC_CRIT = 3'd2,
      SRC_DBG  = 3'd3,
      SRC_NC   = 3'd4,
      SRC_FP   = 3'd5
   } src_e;
endpackage

// File: rtl/isc_arbiter.sv
module isc_arbiter
   import isc_pkg::*;
#(
   parameter bit GUEST_EN = 1'b1
) (
   input  logic  req_mc,
   input  logic  req_crit,
   input  logic  dbg_pend,
   input  logic  req_nc,
   input  logic  req_guest,
   input  logic  fp_pend,
   output logic  take,
   output pair_e pair,
   output src_e  src
);
   logic guest_route;

   generate
      if (GUEST_EN) begin : g_guest
         assign guest_route = req_guest;
      end else begin : g_noguest
         assign guest_route = 1'b0;
      end
   endgenerate

   always_comb begin
      take = 1'b1;
      pair = PR_NORM;
      src  = SRC_NONE;
      if (req_mc) begin
         pair = PR_MCHK;
         src  = SRC_MCHK;
      end else if (req_crit) begin
         pair = PR_CRIT;
         src  = SRC_CRIT;
      end else if (dbg_pend) begin
         pair = PR_CRIT;
         src  = SRC_DBG;
      end else if (req_nc) begin
         pair = guest_route ? PR_GUEST : PR_NORM;
         src  = SRC_NC;
      end else if (fp_pend) begin
         pair = PR_NORM;
         src  = SRC_FP;
      end else begin
         take = 1'b0;
      end
   end
endmodule

// File: rtl/isc_delay_trig.sv
module isc_delay_trig #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   input  logic [AW-1:0] arm_addr,
   input  logic          consume,
   output logic          pend_o,
   output logic [AW-1:0] addr_o
);
   logic          pend_q;
   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         addr_q <= '0;
      end else if (consume) begin
         pend_q <= 1'b0;
      end else if (arm && !pend_q) begin
         pend_q <= 1'b1;
         addr_q <= arm_addr;
      end
   end

   assign pend_o = pend_q;
   assign addr_o = addr_q;

   // R7: a pending trigger keeps its address until it is taken
   assert_pend_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !consume) |=> (pend_q && $stable(addr_q)));
endmodule

// File: rtl/isc_pair_bank.sv
module isc_pair_bank
   import isc_pkg::*;
#(
   parameter int AW = 32,
   parameter int MW = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  pair_e                      widx,
   input  logic [AW-1:0]              wpc,
   input  logic [MW-1:0]              wstate,
   input  pair_e                      ridx,
   output logic [AW-1:0]              rpc,
   output logic [MW-1:0]              rstate,
   output logic [PAIRS-1:0][AW-1:0]   all_pc,
   output logic [PAIRS-1:0][MW-1:0]   all_state
);
   generate
      for (genvar i = 0; i < PAIRS; i++) begin : g_pair
         logic [AW-1:0] pc_q;
         logic [MW-1:0] st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pc_q <= '0;
               st_q <= '0;
            end else if (we && (widx == pair_e'(i))) begin
               pc_q <= wpc;
               st_q <= wstate;
            end
         end
         assign all_pc[i]    = pc_q;
         assign all_state[i] = st_q;
      end
   endgenerate

   assign rpc    = all_pc[ridx];
   assign rstate = all_state[ridx];

   // R1: a write reaches the addressed pair on the next edge
   assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (all_pc[$past(widx)] == $past(wpc)) && (all_state[$past(widx)] == $past(wstate)));
endmodule

// File: rtl/irq_state_capture.sv
module irq_state_capture
   import isc_pkg::*;
#(
   parameter int            AW       = 32,
   parameter int            MW       = 32,
   parameter int            DW       = 4,
   parameter int            DE_BIT   = 9,
   parameter int            FE0_BIT  = 11,
   parameter int            FE1_BIT  = 8,
   parameter bit            GUEST_EN = 1'b1,
   parameter logic [MW-1:0] MC_CLR   = MW'(32'h0000_9200),
   parameter logic [MW-1:0] CRIT_CLR = MW'(32'h0000_8200),
   parameter logic [MW-1:0] NC_CLR   = MW'(32'h0000_8000)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_mc,
   input  logic                      req_crit,
   input  logic                      req_nc,
   input  logic                      req_guest,
   input  logic [AW-1:0]             resume_pc,
   input  logic [AW-1:0]             seq_pc,
   input  logic                      wr_state_v,
   input  logic [MW-1:0]             wr_state,
   input  logic                      ret_v,
   input  logic [1:0]                ret_kind,
   input  logic [DW-1:0]             dbg_evt,
   input  logic [DW-1:0]             dbg_clr,
   input  logic                      fp_exc_pend,
   output logic [MW-1:0]             state_o,
   output logic                      fp_precise_o,
   output logic                      ret_done_o,
   output logic [AW-1:0]             ret_pc_o,
   output logic [DW-1:0]             dbg_status_o,
   output logic [3:0][AW-1:0]        pair_pc_o,
   output logic [3:0][MW-1:0]        pair_state_o
);
   localparam int FEW = 2;

   generate
      if (DE_BIT >= MW || FE0_BIT >= MW || FE1_BIT >= MW) begin : g_bad_bit
         $error("state bit position outside the state word");
      end
      if (DE_BIT == FE0_BIT || DE_BIT == FE1_BIT || FE0_BIT == FE1_BIT) begin : g_bad_dup
         $error("state bit positions must be distinct");
      end
      if (AW < 2 || DW < 1) begin : g_bad_width
         $error("address or status width too small");
      end
   endgenerate

   logic [MW-1:0] state_q;
   logic [DW-1:0] dbsr_q;

   logic          take;
   pair_e         win_pair;
   src_e          win_src;
   logic          dbg_pend, fp_pend;
   logic [AW-1:0] dbg_addr, fp_addr;
   logic [AW-1:0] rd_pc;
   logic [MW-1:0] rd_state;

   isc_arbiter #(.GUEST_EN(GUEST_EN)) u_arb (
      .req_mc(req_mc), .req_crit(req_crit), .dbg_pend(dbg_pend),
      .req_nc(req_nc), .req_guest(req_guest), .fp_pend(fp_pend),
      .take(take), .pair(win_pair), .src(win_src)
   );

   // return and state-write acceptance
   logic          ret_ok, wr_ok, upd;
   logic [MW-1:0] new_state;
   logic [AW-1:0] upd_addr;
   logic [FEW-1:0] fe_old, fe_new;
   logic          dbg_arm, fp_arm;

   assign ret_ok    = ret_v && !take;
   assign wr_ok     = wr_state_v && !take && !ret_v;
   assign upd       = ret_ok || wr_ok;
   assign new_state = ret_ok ? rd_state : wr_state;
   assign upd_addr  = ret_ok ? rd_pc : seq_pc;
   assign fe_old    = {state_q[FE0_BIT], state_q[FE1_BIT]};
   assign fe_new    = {new_state[FE0_BIT], new_state[FE1_BIT]};
   assign dbg_arm   = upd && new_state[DE_BIT] && !state_q[DE_BIT] && (|dbsr_q);
   assign fp_arm    = upd && fp_exc_pend && (fe_new != fe_old) && (fe_new != '0);

   isc_delay_trig #(.AW(AW)) u_dbg_trig (
      .clk(clk), .rst_n(rst_n), .arm(dbg_arm), .arm_addr(upd_addr),
      .consume(take && (win_src == SRC_DBG)), .pend_o(dbg_pend), .addr_o(dbg_addr)
   );

   isc_delay_trig #(.AW(AW)) u_fp_trig (
      .clk(clk), .rst_n(rst_n), .arm(fp_arm), .arm_addr(upd_addr),
      .consume(take && (win_src == SRC_FP)), .pend_o(fp_pend), .addr_o(fp_addr)
   );

   // save address and clear mask for the winner
   logic [AW-1:0] save_pc;
   logic [MW-1:0] clr_mask;

   always_comb begin
      save_pc  = resume_pc;
      clr_mask = NC_CLR;
      unique case (win_src)
         SRC_MCHK: clr_mask = MC_CLR;
         SRC_CRIT: clr_mask = CRIT_CLR;
         SRC_DBG:  begin clr_mask = CRIT_CLR; save_pc = dbg_addr; end
         SRC_FP:   save_pc = fp_addr;
         default:  clr_mask = NC_CLR;
      endcase
   end

   isc_pair_bank #(.AW(AW), .MW(MW)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(take), .widx(win_pair),
      .wpc(save_pc), .wstate(state_q), .ridx(pair_e'(ret_kind)),
      .rpc(rd_pc), .rstate(rd_state), .all_pc(pair_pc_o), .all_state(pair_state_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
         dbsr_q  <= '0;
      end else begin
         dbsr_q <= (dbsr_q & ~dbg_clr) | dbg_evt;
         if (take)
            state_q <= state_q & ~clr_mask;
         else if (upd)
            state_q <= new_state;
      end
   end

   assign state_o      = state_q;
   assign fp_precise_o = (fe_old == '0);
   assign ret_done_o   = ret_ok;
   assign ret_pc_o     = rd_pc;
   assign dbg_status_o = dbsr_q;

   // R3: machine check saves resume_pc into its own pair
   assert_mc_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_mc |=> (pair_pc_o[3] == $past(resume_pc)));

   // R1: a critical win leaves the noncritical pair untouched
   assert_nc_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_crit && !req_mc) |=> $stable(pair_pc_o[0]) && $stable(pair_state_o[0]));

   // R4: machine check wins over critical and noncritical
   assert_mc_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_mc && (req_crit || req_nc)) |=> $stable(pair_pc_o[1]) && $stable(pair_pc_o[0]));

   // R6: without a clear no status bit drops
   assert_dbsr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_clr == '0) |=> (($past(dbsr_q) & ~dbsr_q) == '0));
endmodule

// File: tb/sim_irq_state_capture.sv
`timescale 1ns/1ps
module sim_irq_state_capture;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_mc, req_crit, req_nc, req_guest;
   logic [31:0] resume_pc, seq_pc, wr_state;
   logic        wr_state_v, ret_v, fp_exc_pend;
   logic [1:0]  ret_kind;
   logic [3:0]  dbg_evt, dbg_clr;
   logic [31:0] state_o, ret_pc_o;
   logic        fp_precise_o, ret_done_o;
   logic [3:0]  dbg_status_o;
   logic [3:0][31:0] pair_pc_o, pair_state_o;

   int applied = 0;
   int bad     = 0;
   bit done    = 0;

   always #4 clk = ~clk;

   irq_state_capture u0 (
      .clk(clk), .rst_n(rst_n), .req_mc(req_mc), .req_crit(req_crit), .req_nc(req_nc),
      .req_guest(req_guest), .resume_pc(resume_pc), .seq_pc(seq_pc),
      .wr_state_v(wr_state_v), .wr_state(wr_state), .ret_v(ret_v), .ret_kind(ret_kind),
      .dbg_evt(dbg_evt), .dbg_clr(dbg_clr), .fp_exc_pend(fp_exc_pend),
      .state_o(state_o), .fp_precise_o(fp_precise_o), .ret_done_o(ret_done_o),
      .ret_pc_o(ret_pc_o), .dbg_status_o(dbg_status_o),
      .pair_pc_o(pair_pc_o), .pair_state_o(pair_state_o)
   );

   typedef struct packed {
      logic [3:0]  req;     // mc, crit, nc, guest
      logic [31:0] rpc;
      logic        wv;
      logic [31:0] wd;
      logic        rv;
      logic [1:0]  rk;
      logic [31:0] spc;
      logic [3:0]  ev;
      logic        chk;
      logic [1:0]  cidx;
      logic [31:0] epc;
      logic [31:0] esv;     // expected saved word in pair cidx
      logic [31:0] est;     // expected live word
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{4'b0000, 32'h0,   1'b1, 32'h8000, 1'b0, 2'd0, 32'h0,   4'h0, 1'b0, 2'd0, 32'h0,   32'h0,    32'h8000},
      '{4'b0010, 32'h100, 1'b0, 32'h0,    1'b0, 2'd0, 32'h0,   4'h0, 1'b1, 2'd0, 32'h100, 32'h8000, 32'h0},
      '{4'b0011, 32'h200, 1'b0, 32'h0,    1'b0, 2'd0, 32'h0,   4'h0, 1'b1, 2'd2, 32'h200, 32'h0,    32'h0},
      '{4'b0100, 32'h300, 1'b0, 32'h0,    1'b0, 2'd0, 32'h0,   4'h0, 1'b1, 2'd1, 32'h300, 32'h0,    32'h0},
      '{4'b1110, 32'h400, 1'b0, 32'h0,    1'b0, 2'd0, 32'h0,   4'h0, 1'b1, 2'd3, 32'h400, 32'h0,    32'h0},
      '{4'b0000, 32'h0,   1'b0, 32'h0,    1'b1, 2'd0, 32'h0,   4'h0, 1'b1, 2'd0, 32'h100, 32'h8000, 32'h8000},
      '{4'b0000, 32'h0,   1'b0, 32'h0,    1'b0, 2'd0, 32'h0,   4'h2, 1'b0, 2'd0, 32'h0,   32'h0,    32'h8000},
      '{4'b0000, 32'h0,   1'b1, 32'h8200, 1'b0, 2'd0, 32'h504, 4'h0, 1'b0, 2'd0, 32'h0,   32'h0,    32'h8200},
      '{4'b0000, 32'h0,   1'b0, 32'h0,    1'b0, 2'd0, 32'h0,   4'h0, 1'b1, 2'd1, 32'h504, 32'h8200, 32'h0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      applied++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle();
      {req_mc, req_crit, req_nc, req_guest} = 4'b0;
      resume_pc = '0; seq_pc = '0; wr_state_v = 1'b0; wr_state = '0;
      ret_v = 1'b0; ret_kind = 2'd0; dbg_evt = '0; dbg_clr = '0; fp_exc_pend = 1'b0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 20000);
      bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      idle();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      check("R12 state", state_o, 32'h0);
      check("R12 status", {28'h0, dbg_status_o}, 32'h0);
      for (int i = 0; i < 4; i++) check("R12 pair pc", pair_pc_o[i], 32'h0);

      // table walk: R1 R2 R3 R4 R5 R7 R11
      for (int v = 0; v < NV; v++) begin
         {req_mc, req_crit, req_nc, req_guest} = VECS[v].req;
         resume_pc = VECS[v].rpc; wr_state_v = VECS[v].wv; wr_state = VECS[v].wd;
         ret_v = VECS[v].rv; ret_kind = VECS[v].rk; seq_pc = VECS[v].spc; dbg_evt = VECS[v].ev;
         step();
         idle();
         check($sformatf("R5 vector %0d live word", v), state_o, VECS[v].est);
         if (VECS[v].chk) begin
            check($sformatf("R1/R2/R3/R7 vector %0d pair pc", v), pair_pc_o[VECS[v].cidx], VECS[v].epc);
            check($sformatf("R1/R2/R3 vector %0d pair word", v), pair_state_o[VECS[v].cidx], VECS[v].esv);
         end
      end
      check("R2 guest pair kept", pair_pc_o[2], 32'h200);
      check("R6 status held", {28'h0, dbg_status_o}, 32'h2);

      // R6 write-one-to-clear
      dbg_clr = 4'hF; step(); idle();
      check("R6 cleared", {28'h0, dbg_status_o}, 32'h0);

      // R7 no trigger when status is empty
      wr_state_v = 1'b1; wr_state = 32'h8200; seq_pc = 32'h700; step(); idle();
      step();
      check("R7 no delayed irq", state_o, 32'h8200);

      // R8 return enables debug: target address, not seq_pc
      req_crit = 1'b1; resume_pc = 32'h620; step(); idle();
      check("R1 crit pc", pair_pc_o[1], 32'h620);
      dbg_evt = 4'h1; step(); idle();
      ret_v = 1'b1; ret_kind = 2'd1; seq_pc = 32'h999;
      #1 check("R11 ret target crit", ret_pc_o, 32'h620);
      @(negedge clk); idle();
      check("R11 word restored", state_o, 32'h8200);
      step();
      check("R8 saved target", pair_pc_o[1], 32'h620);
      check("R8 irq taken", state_o, 32'h0);

      // R9 delayed floating-point trigger, R10 precise flag
      fp_exc_pend = 1'b1; wr_state_v = 1'b1; wr_state = 32'h0800; seq_pc = 32'h804;
      step(); idle();
      check("R10 imprecise", {31'h0, fp_precise_o}, 32'h0);
      step();
      check("R9 saved pc", pair_pc_o[0], 32'h804);
      check("R9 saved word", pair_state_o[0], 32'h0800);
      wr_state_v = 1'b1; wr_state = 32'h0; step(); idle();
      check("R10 precise", {31'h0, fp_precise_o}, 32'h1);
      wr_state_v = 1'b1; wr_state = 32'h0100; seq_pc = 32'hA00; step(); idle();
      step();
      check("R9 no pend no irq", pair_pc_o[0], 32'h804);

      // R4 interrupt beats a return in the same cycle
      req_nc = 1'b1; resume_pc = 32'hB00; ret_v = 1'b1; ret_kind = 2'd3;
      #1 check("R4 ret blocked", {31'h0, ret_done_o}, 32'h0);
      @(negedge clk); idle();
      check("R4 irq pair", pair_pc_o[0], 32'hB00);
      check("R4 live word", state_o, 32'h0100);

      // R11 machine-check return
      ret_v = 1'b1; ret_kind = 2'd3;
      #1 check("R11 ret target mc", ret_pc_o, 32'h400);
      @(negedge clk); idle();
      check("R11 mc word", state_o, 32'h0);

      finish_run();
   end
endmodule